// File: doc/BRIEF.md
# Transaction Hazard Detection Stage

This block is one stage of a pipelined validator for optimistic transactions. When a transaction enters, it receives a commit timestamp from a counter inside the stage. At the same moment the stage latches the timestamp of the oldest transaction still in flight, which serves as a lower bound. The stage then accepts the transaction's read-set addresses at up to one per cycle. It forwards each address to an external last-writer lookup and filters the returned writer timestamps. A writer counts as a possible write-after-read hazard only if its timestamp is no older than the lower bound and strictly older than the transaction's own timestamp.

The youngest such writer becomes the conflict pointer. If no writer qualifies, the stage reports at once that no second validation is needed. If one does qualify, the stage waits for a completion broadcast for that timestamp. Either a commit or an abort releases it. The stage then reports that the transaction must be validated a second time, and gives the timestamp it waited on and that writer's outcome. Completion broadcasts are recorded in a ring of done flags indexed by timestamp. A writer that finished before the read walk ended therefore releases the stage with no further broadcast.

Top module: `hazard_detect_stage`

## Requirements
- R1: After reset the stage assigns timestamp 0 to the first accepted entry (entry_valid and entry_ready both high at a clock edge). Each later accepted entry gets the previous timestamp plus one, and res_ts carries that value.
- R2: entry_oldest_ts is sampled only on the cycle an entry is accepted. Changes to it while the transaction is in the stage have no effect on the result.
- R3: While a transaction walks its reads, rd_ready is high when fewer than MAX_OUT lookups are outstanding. Each accepted read raises lk_req_valid in the same cycle with lk_req_addr equal to rd_addr. rd_ready stays low once the read flagged by rd_last has been accepted, and stays low outside a walk.
- R4: A lookup result older than the latched lower bound is ignored. A result equal to the lower bound is a possible conflict.
- R5: A lookup result equal to or younger than the transaction's own timestamp is ignored.
- R6: The conflict pointer takes the youngest relevant result. If no result is relevant, the report has res_revalidate=0, res_wait_ts=0 and res_wait_commit=0.
- R7: With a conflict pointer set, no report appears until a broadcast whose cmp_ts equals the pointer has been seen; broadcasts of other timestamps do not release the stage. The report then has res_revalidate=1, res_wait_ts equal to the pointer, and res_wait_commit equal to that broadcast's cmp_commit (1 = commit, 0 = abort).
- R8: If the pointer's writer was broadcast as complete at any time after its own entry was accepted, including before the current transaction entered, the report follows without a new broadcast. res_wait_commit then carries the recorded outcome.
- R9: res_valid is high for exactly one cycle, and the cycle after it has entry_ready high.
- R10: After reset, entry_ready is high and res_valid, rd_ready and lk_req_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| entry_valid | input | 1 | A transaction asks to enter the stage |
| entry_ready | output | 1 | Stage is idle and accepts an entry |
| entry_oldest_ts | input | 16 | Timestamp of the oldest in-flight transaction |
| rd_valid | input | 1 | Read-set address is valid |
| rd_ready | output | 1 | Stage accepts the read address |
| rd_addr | input | AW | Read-set address |
| rd_last | input | 1 | This read is the last of the set |
| lk_req_valid | output | 1 | Last-writer lookup request |
| lk_req_addr | output | AW | Address looked up |
| lk_rsp_valid | input | 1 | Lookup response, in request order |
| lk_rsp_ts | input | 16 | Timestamp of the last writer of that address |
| cmp_valid | input | 1 | Completion broadcast valid |
| cmp_ts | input | 16 | Timestamp of the completing transaction |
| cmp_commit | input | 1 | 1 = committed, 0 = aborted |
| res_valid | output | 1 | One-cycle result pulse |
| res_ts | output | 16 | Own timestamp of the reported transaction |
| res_revalidate | output | 1 | Second validation required |
| res_wait_ts | output | 16 | Writer that was waited on |
| res_wait_commit | output | 1 | Outcome of that writer |

## Verification
Several properties hold on every cycle: each lookup request mirrors an accepted read, the count of outstanding lookups stays bounded, the result is a single pulse, a reported wait timestamp lies between the latched lower bound and the own timestamp, the lower bound stays fixed during a transaction, and reported timestamps follow the number of entries. The filtering outcome depends on the lookup values, and the release on the order of broadcasts. The bench's scenarios therefore cover these: results equal to each bound, several relevant writers of different ages, broadcasts for unrelated writers, a writer that finished before its reader entered, and a change of the oldest in-flight input during a walk.

// File: rtl/hd_pkg.sv
package hd_pkg;

    parameter int TS_W = 16;

    typedef logic [TS_W-1:0] ts_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WALK,
        ST_WAIT,
        ST_REPORT
    } hd_state_e;

    // Conflict pointer: valid=0 stands for "none yet" (infinity).
    typedef struct packed {
        logic valid;
        ts_t  ts;
    } tsptr_t;

    typedef struct packed {
        logic revalidate;
        logic commit;
        ts_t  wait_ts;
    } hd_result_t;

    // A writer may conflict when it is not older than the lower bound
    // and strictly older than the reader itself.
    function automatic logic ts_relevant(ts_t r, ts_t lo, ts_t own);
        return (r >= lo) && (r < own);
    endfunction

    // Keep the youngest candidate seen so far.
    function automatic tsptr_t ptr_merge(tsptr_t cur, ts_t r);
        tsptr_t nxt;
        nxt = cur;
        if (!cur.valid || (r > cur.ts)) begin
            nxt.valid = 1'b1;
            nxt.ts    = r;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/hd_ts_alloc.sv
module hd_ts_alloc
    import hd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic alloc,
    output ts_t  ts_o
);
    ts_t cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (alloc) begin
            cnt_q <= cnt_q + ts_t'(1);
        end
    end

    assign ts_o = cnt_q;
endmodule

// File: rtl/hd_conflict_track.sv
module hd_conflict_track
    import hd_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   clear,
    input  logic   upd_valid,
    input  ts_t    upd_ts,
    input  ts_t    lower,
    input  ts_t    own,
    output tsptr_t ptr_o
);
    tsptr_t ptr_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            ptr_q <= '0;
        end else if (upd_valid && ts_relevant(upd_ts, lower, own)) begin
            ptr_q <= ptr_merge(ptr_q, upd_ts);
        end
    end

    assign ptr_o = ptr_q;
endmodule

// File: rtl/hd_done_ring.sv
module hd_done_ring
    import hd_pkg::*;
#(
    parameter int WINDOW = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic alloc,
    input  ts_t  alloc_ts,
    input  logic cmp_valid,
    input  ts_t  cmp_ts,
    input  logic cmp_commit,
    input  ts_t  q_ts,
    output logic q_done,
    output logic q_commit
);
    localparam int IDXW = (WINDOW > 1) ? $clog2(WINDOW) : 1;

    logic [IDXW-1:0]   alloc_idx, cmp_idx, q_idx;
    logic [WINDOW-1:0] done_vec, commit_vec;

    assign alloc_idx = IDXW'(alloc_ts % ts_t'(WINDOW));
    assign cmp_idx   = IDXW'(cmp_ts % ts_t'(WINDOW));
    assign q_idx     = IDXW'(q_ts % ts_t'(WINDOW));

    for (genvar i = 0; i < WINDOW; i++) begin : g_slot
        logic slot_done_q, slot_commit_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                slot_done_q   <= 1'b1;
                slot_commit_q <= 1'b0;
            end else if (alloc && (alloc_idx == IDXW'(i))) begin
                slot_done_q   <= 1'b0;
                slot_commit_q <= 1'b0;
            end else if (cmp_valid && (cmp_idx == IDXW'(i))) begin
                slot_done_q   <= 1'b1;
                slot_commit_q <= cmp_commit;
            end
        end

        assign done_vec[i]   = slot_done_q;
        assign commit_vec[i] = slot_commit_q;
    end

    assign q_done   = done_vec[q_idx];
    assign q_commit = commit_vec[q_idx];
endmodule

// File: rtl/hazard_detect_stage.sv
module hazard_detect_stage
    import hd_pkg::*;
#(
    parameter int AW      = 32,
    parameter int MAX_OUT = 4,
    parameter int WINDOW  = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          entry_valid,
    output logic          entry_ready,
    input  logic [15:0]   entry_oldest_ts,
    input  logic          rd_valid,
    output logic          rd_ready,
    input  logic [AW-1:0] rd_addr,
    input  logic          rd_last,
    output logic          lk_req_valid,
    output logic [AW-1:0] lk_req_addr,
    input  logic          lk_rsp_valid,
    input  logic [15:0]   lk_rsp_ts,
    input  logic          cmp_valid,
    input  logic [15:0]   cmp_ts,
    input  logic          cmp_commit,
    output logic          res_valid,
    output logic [15:0]   res_ts,
    output logic          res_revalidate,
    output logic [15:0]   res_wait_ts,
    output logic          res_wait_commit
);
    localparam int OW = $clog2(MAX_OUT + 1);

    hd_state_e      state_q;
    ts_t            own_q, lower_q, alloc_ts;
    logic           last_q;
    logic [OW-1:0]  outst_q;
    tsptr_t         ptr;
    logic           ring_done, ring_commit;
    hd_result_t     res_q;

    logic entry_fire, rd_fire, rsp_take, walk_end, release_ok;

    assign entry_ready = (state_q == ST_IDLE);
    assign entry_fire  = entry_valid && entry_ready;
    assign rd_ready    = (state_q == ST_WALK) && !last_q && (outst_q < OW'(MAX_OUT));
    assign rd_fire     = rd_valid && rd_ready;
    assign rsp_take    = lk_rsp_valid && (state_q == ST_WALK);
    assign walk_end    = (state_q == ST_WALK) && last_q && (outst_q == '0);
    assign release_ok  = ptr.valid && ring_done;

    assign lk_req_valid = rd_fire;
    assign lk_req_addr  = rd_addr;

    hd_ts_alloc u_alloc (
        .clk   (clk),
        .rst   (rst),
        .alloc (entry_fire),
        .ts_o  (alloc_ts)
    );

    hd_conflict_track u_track (
        .clk       (clk),
        .rst       (rst),
        .clear     (entry_fire),
        .upd_valid (rsp_take),
        .upd_ts    (lk_rsp_ts),
        .lower     (lower_q),
        .own       (own_q),
        .ptr_o     (ptr)
    );

    hd_done_ring #(.WINDOW(WINDOW)) u_ring (
        .clk        (clk),
        .rst        (rst),
        .alloc      (entry_fire),
        .alloc_ts   (alloc_ts),
        .cmp_valid  (cmp_valid),
        .cmp_ts     (cmp_ts),
        .cmp_commit (cmp_commit),
        .q_ts       (ptr.ts),
        .q_done     (ring_done),
        .q_commit   (ring_commit)
    );

    // Lookups in flight.
    always_ff @(posedge clk) begin
        if (rst || entry_fire) begin
            outst_q <= '0;
        end else begin
            outst_q <= outst_q + OW'(rd_fire) - OW'(rsp_take);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            own_q   <= '0;
            lower_q <= '0;
            last_q  <= 1'b0;
            res_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (entry_fire) begin
                        own_q   <= alloc_ts;
                        lower_q <= entry_oldest_ts;
                        last_q  <= 1'b0;
                        state_q <= ST_WALK;
                    end
                end
                ST_WALK: begin
                    if (rd_fire && rd_last) begin
                        last_q <= 1'b1;
                    end
                    if (walk_end) begin
                        if (!ptr.valid) begin
                            res_q   <= '0;
                            state_q <= ST_REPORT;
                        end else if (release_ok) begin
                            res_q   <= '{revalidate: 1'b1, commit: ring_commit, wait_ts: ptr.ts};
                            state_q <= ST_REPORT;
                        end else begin
                            state_q <= ST_WAIT;
                        end
                    end
                end
                ST_WAIT: begin
                    if (release_ok) begin
                        res_q   <= '{revalidate: 1'b1, commit: ring_commit, wait_ts: ptr.ts};
                        state_q <= ST_REPORT;
                    end
                end
                ST_REPORT: begin
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign res_valid       = (state_q == ST_REPORT);
    assign res_ts          = own_q;
    assign res_revalidate  = res_q.revalidate;
    assign res_wait_ts     = res_q.wait_ts;
    assign res_wait_commit = res_q.commit;
endmodule

// File: rtl/hazard_detect_stage_chk.sv
module hazard_detect_stage_chk
    import hd_pkg::*;
#(
    parameter int AW      = 32,
    parameter int MAX_OUT = 4,
    parameter int WINDOW  = 32,
    parameter int OW      = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          entry_valid,
    input logic          entry_ready,
    input logic          rd_valid,
    input logic          rd_ready,
    input logic [AW-1:0] rd_addr,
    input logic          lk_req_valid,
    input logic [AW-1:0] lk_req_addr,
    input logic          res_valid,
    input logic [15:0]   res_ts,
    input logic          res_revalidate,
    input logic [15:0]   res_wait_ts,
    input logic          res_wait_commit,
    input hd_state_e     state_q,
    input ts_t           own_q,
    input ts_t           lower_q,
    input logic [OW-1:0] outst_q
);
    logic [15:0] n_entries;

    always_ff @(posedge clk) begin
        if (rst) begin
            n_entries <= '0;
        end else if (entry_valid && entry_ready) begin
            n_entries <= n_entries + 16'd1;
        end
    end

    assert_ts_sequence_R1: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (res_ts == n_entries - 16'd1));

    assert_lower_held_R2: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE) |=> (state_q == ST_IDLE || $stable(lower_q)));

    assert_span_in_window_R8: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE) |-> ((own_q - lower_q) < ts_t'(WINDOW)));

    assert_lookup_mirrors_read_R3: assert property (@(posedge clk) disable iff (rst)
        lk_req_valid |-> (rd_valid && rd_ready && lk_req_addr == rd_addr));

    assert_no_read_when_idle_R3: assert property (@(posedge clk) disable iff (rst)
        rd_ready |-> !entry_ready);

    assert_outstanding_bound_R3: assert property (@(posedge clk) disable iff (rst)
        outst_q <= OW'(MAX_OUT));

    assert_clean_result_R6: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_revalidate) |-> (res_wait_ts == 16'd0 && !res_wait_commit));

    assert_wait_ts_bounds_R7: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_revalidate) |-> (res_wait_ts >= lower_q && res_wait_ts < res_ts));

    assert_single_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> (!res_valid && entry_ready));
endmodule

bind hazard_detect_stage hazard_detect_stage_chk #(
    .AW(AW), .MAX_OUT(MAX_OUT), .WINDOW(WINDOW), .OW(OW)
) u_chk (
    .clk(clk), .rst(rst),
    .entry_valid(entry_valid), .entry_ready(entry_ready),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .lk_req_valid(lk_req_valid), .lk_req_addr(lk_req_addr),
    .res_valid(res_valid), .res_ts(res_ts), .res_revalidate(res_revalidate),
    .res_wait_ts(res_wait_ts), .res_wait_commit(res_wait_commit),
    .state_q(state_q), .own_q(own_q), .lower_q(lower_q), .outst_q(outst_q)
);

// File: tb/hazard_detect_stage_tb.sv
module hazard_detect_stage_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic          entry_valid, entry_ready;
    logic [15:0]   entry_oldest_ts;
    logic          rd_valid, rd_ready, rd_last;
    logic [AW-1:0] rd_addr;
    logic          lk_req_valid, lk_rsp_valid;
    logic [AW-1:0] lk_req_addr;
    logic [15:0]   lk_rsp_ts;
    logic          cmp_valid, cmp_commit;
    logic [15:0]   cmp_ts;
    logic          res_valid, res_revalidate, res_wait_commit;
    logic [15:0]   res_ts, res_wait_ts;

    int checks = 0;
    int errors = 0;
    int exp_ts = 0;
    int lk_cnt = 0;
    int lk_sum = 0;

    logic [15:0]   lk_tab [16];
    logic          p1_v, p2_v;
    logic [AW-1:0] p1_a, p2_a;

    bit          got;
    logic [15:0] g_ts, g_wts;
    logic        g_rev, g_com;

    always #(CLK_PERIOD/2) clk = ~clk;

    hazard_detect_stage #(.AW(AW), .MAX_OUT(4), .WINDOW(32)) u_dut (
        .clk(clk), .rst(rst),
        .entry_valid(entry_valid), .entry_ready(entry_ready), .entry_oldest_ts(entry_oldest_ts),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_last(rd_last),
        .lk_req_valid(lk_req_valid), .lk_req_addr(lk_req_addr),
        .lk_rsp_valid(lk_rsp_valid), .lk_rsp_ts(lk_rsp_ts),
        .cmp_valid(cmp_valid), .cmp_ts(cmp_ts), .cmp_commit(cmp_commit),
        .res_valid(res_valid), .res_ts(res_ts), .res_revalidate(res_revalidate),
        .res_wait_ts(res_wait_ts), .res_wait_commit(res_wait_commit)
    );

    // Last-writer lookup model: two-cycle latency, in order.
    always @(posedge clk) begin
        if (rst) begin
            p1_v <= 1'b0;
            p2_v <= 1'b0;
        end else begin
            p1_v <= lk_req_valid;
            p1_a <= lk_req_addr;
            p2_v <= p1_v;
            p2_a <= p1_a;
        end
        if (!rst && lk_req_valid) begin
            lk_cnt = lk_cnt + 1;
            lk_sum = lk_sum + int'(lk_req_addr);
        end
    end
    assign lk_rsp_valid = p2_v;
    assign lk_rsp_ts    = lk_tab[p2_a[3:0]];

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic set_tab(input logic [15:0] v0, input logic [15:0] v1, input logic [15:0] v2,
                           input logic [15:0] v3, input logic [15:0] v4);
        for (int i = 0; i < 16; i++) lk_tab[i] = 16'd0;
        lk_tab[0] = v0; lk_tab[1] = v1; lk_tab[2] = v2; lk_tab[3] = v3; lk_tab[4] = v4;
    endtask

    task automatic start_txn(input int oldest);
        @(negedge clk);
        entry_valid = 1'b1;
        entry_oldest_ts = 16'(oldest);
        #1;
        while (!entry_ready) begin @(negedge clk); #1; end
        @(posedge clk);
        @(negedge clk);
        entry_valid = 1'b0;
    endtask

    task automatic send_reads(input int n);
        for (int i = 0; i < n; i++) begin
            if (i != 0) @(negedge clk);
            rd_valid = 1'b1;
            rd_addr  = AW'(i);
            rd_last  = (i == n - 1);
            #1;
            while (!rd_ready) begin @(negedge clk); #1; end
            @(posedge clk);
        end
        @(negedge clk);
        rd_valid = 1'b0;
        rd_last  = 1'b0;
    endtask

    task automatic broadcast(input int ts, input bit commit);
        @(negedge clk);
        cmp_valid = 1'b1;
        cmp_ts = 16'(ts);
        cmp_commit = commit;
        @(negedge clk);
        cmp_valid = 1'b0;
    endtask

    task automatic wait_result(input int maxc);
        got = 1'b0;
        for (int i = 0; i < maxc; i++) begin
            @(negedge clk);
            if (res_valid) begin
                got = 1'b1;
                g_ts = res_ts; g_rev = res_revalidate; g_wts = res_wait_ts; g_com = res_wait_commit;
                break;
            end
        end
        chk(got, "R9", "result appeared", got, 1);
        if (got) begin
            @(negedge clk);
            chk(!res_valid && entry_ready, "R9", "single pulse then ready",
                {res_valid, entry_ready}, 2'b01);
        end
    endtask

    task automatic expect_silence(input int n, input string req);
        bit seen = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (res_valid) seen = 1'b1;
        end
        chk(!seen, req, "no result while waiting", seen, 0);
    endtask

    task automatic check_res(input string req, input bit rev, input int wts, input bit com);
        chk(g_ts == 16'(exp_ts), "R1", "res_ts", g_ts, exp_ts);
        chk(g_rev == rev, req, "res_revalidate", g_rev, rev);
        chk(g_wts == 16'(wts), req, "res_wait_ts", g_wts, wts);
        chk(g_com == com, req, "res_wait_commit", g_com, com);
        exp_ts++;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        entry_valid = 1'b0; entry_oldest_ts = '0;
        rd_valid = 1'b0; rd_addr = '0; rd_last = 1'b0;
        cmp_valid = 1'b0; cmp_ts = '0; cmp_commit = 1'b0;
        set_tab(0, 0, 0, 0, 0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R10: idle outputs after reset
        chk(entry_ready && !res_valid && !rd_ready && !lk_req_valid, "R10", "reset outputs",
            {entry_ready, res_valid, rd_ready, lk_req_valid}, 4'b1000);
    endtask

    // R1: timestamps start at 0 and count up; empty window gives no hazard.
    task automatic t_warmup();
        set_tab(0, 0, 0, 0, 0);
        for (int k = 0; k < 6; k++) begin
            start_txn(exp_ts);
            send_reads(1);
            wait_result(40);
            check_res("R1", 1'b0, 0, 1'b0);
        end
    endtask

    // R4/R5: older than lower bound, equal to own, younger than own all ignored.
    task automatic t_ignored();
        set_tab(2, 1, 6, 9, 0);
        start_txn(3);
        send_reads(4);
        wait_result(40);
        check_res("R5", 1'b0, 0, 1'b0);
    endtask

    // R4/R7: result equal to lower bound counts; unrelated broadcast does not release.
    task automatic t_boundary();
        set_tab(3, 2, 0, 0, 0);
        start_txn(3);
        send_reads(3);
        expect_silence(12, "R7");
        broadcast(4, 1'b1);
        expect_silence(6, "R7");
        broadcast(3, 1'b0);
        wait_result(20);
        check_res("R4", 1'b1, 3, 1'b0);
    endtask

    // R6/R7: youngest relevant writer is chosen and waited for.
    task automatic t_youngest();
        set_tab(2, 5, 4, 8, 1);
        start_txn(2);
        send_reads(5);
        expect_silence(10, "R7");
        broadcast(2, 1'b1);
        expect_silence(6, "R6");
        broadcast(5, 1'b1);
        wait_result(20);
        check_res("R6", 1'b1, 5, 1'b1);
    endtask

    // R8: writer finished before this transaction entered.
    task automatic t_early();
        broadcast(7, 1'b1);
        set_tab(7, 6, 0, 0, 0);
        start_txn(4);
        send_reads(2);
        wait_result(20);
        check_res("R8", 1'b1, 7, 1'b1);
    endtask

    // R2: a later change of the oldest in-flight input has no effect.
    task automatic t_snapshot();
        set_tab(5, 0, 0, 0, 0);
        start_txn(6);
        entry_oldest_ts = 16'd0;
        send_reads(1);
        wait_result(40);
        check_res("R2", 1'b0, 0, 1'b0);
    endtask

    // R3: every accepted read becomes one lookup with the same address.
    task automatic t_stream();
        int c0, s0;
        set_tab(0, 0, 0, 0, 0);
        c0 = lk_cnt; s0 = lk_sum;
        start_txn(exp_ts);
        send_reads(8);
        #1;
        chk(!rd_ready, "R3", "rd_ready low after last", rd_ready, 0);
        wait_result(40);
        chk(lk_cnt - c0 == 8, "R3", "lookup count", lk_cnt - c0, 8);
        chk(lk_sum - s0 == 28, "R3", "lookup address sum", lk_sum - s0, 28);
        check_res("R3", 1'b0, 0, 1'b0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_warmup();
        t_ignored();
        t_boundary();
        t_youngest();
        t_early();
        t_snapshot();
        t_stream();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule